// File: doc/BRIEF.md
# Per-Lane Transmit Equalization Programmer

This block loads transmit driver equalization settings into a serial transceiver's per-lane register space. A request names how many lanes are active and carries, for each lane, a 2-bit voltage-swing level and a 2-bit pre-emphasis level. The block first checks the request as a whole. It rejects a request with an unsupported lane count or with any active lane whose two levels add up to more than three. A rejected request gets an error response and causes no register traffic.

A request that passes the check is carried out one lane at a time, lowest lane first. For each lane the block freezes the analog driver by setting a hold bit with a read-modify-write. It then writes a fixed control word and three coefficients taken from a swing-by-pre-emphasis table. Last, it releases the hold bit with a second read-modify-write. All traffic goes out on a simple register master port, with one transaction outstanding at a time. When the last lane is finished, a success response is returned.

Top module: `txeq_prog`

## Requirements
- R1: A request whose lane count is not 1, 2 or 4, or exceeds the parameter PHYS_LANES, receives a response with rsp_err=1 and causes no register transaction.
- R2: A request in which an active lane (index below the lane count) has swing + pre-emphasis greater than 3 receives rsp_err=1 with no register transaction. The levels of lanes at or above the lane count are ignored. Lane i swing is req_swing[2i+1:2i] and lane i pre-emphasis is req_pre[2i+1:2i].
- R3: For each lane, a valid request produces exactly 8 transactions in this order: read hold register, write hold register, write control, write drive, write main multiplier, write post multiplier, read hold register, write hold register.
- R4: Every transaction address is the register offset ORed with the lane index shifted left by 11. The default offsets are: hold 0x1079C, control 0x10100, drive 0x10318, main 0x10140, post 0x10130.
- R5: The first hold write carries the first read's data with bit 0 set. The second hold write carries the second read's data with bit 0 cleared. All other bits are kept as read.
- R6: The control write carries 0x08A4 and the drive write carries 0x0003.
- R7: The main/post values in hex are as follows. Swing 0, pre-emphasis 0..3: 2A/00, 1F/14, 12/20, 00/2A. Swing 1, pre-emphasis 0..2: 1F/00, 13/12, 00/1F. Swing 2, pre-emphasis 0..1: 13/00, 00/13. Swing 3, pre-emphasis 0: 00/00.
- R8: Only lanes 0 to count-1 are programmed, in ascending order, and a success response (rsp_err=0) follows the last lane's final write.
- R9: m_req stays high with m_we, m_addr and m_wdata unchanged until m_ready is seen. A read completes only on m_rvalid, and no new transaction is issued before it completes.
- R10: req_ready is high only while no request is in progress. rsp_valid stays high, with rsp_err unchanged, until rsp_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_lanes | input | 3 | Number of lanes to program |
| req_swing | input | 2*PHYS_LANES | Per-lane swing levels, lane i at bits 2i+1:2i |
| req_pre | input | 2*PHYS_LANES | Per-lane pre-emphasis levels, lane i at bits 2i+1:2i |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Request was rejected |
| m_req | output | 1 | Register transaction request |
| m_we | output | 1 | 1 write, 0 read |
| m_addr | output | ADDR_W | Register address |
| m_wdata | output | DATA_W | Write data |
| m_ready | input | 1 | Transaction accepted |
| m_rdata | input | DATA_W | Read data |
| m_rvalid | input | 1 | Read data valid |

## Verification
A wrong step counter or a wrong lane index shows on the master port at the very next issued transaction, as an address outside the expected offset or lane field, or as a transaction out of order. A corrupt hold register or a wrong table lookup shows up as wrong write data within the same lane's sequence. A validation fault shows when the response arrives: either a spurious error, or register traffic that should never have happened. So every such fault appears at the ports within one request.

// File: rtl/txeq_pkg.sv
// Shared types and constants for the transmit equalization programmer.
// Assumes 2-bit level fields and a 3-bit lane count field.
package txeq_pkg;
    localparam int LVL_W = 2;
    localparam int CNT_W = 3;
    localparam logic [15:0] CTRL_WORD = 16'h08A4;
    localparam logic [15:0] DRV_WORD  = 16'h0003;

    typedef enum logic [2:0] {
        ST_FRZ_RD, ST_FRZ_WR, ST_CTRL, ST_DRV,
        ST_MAIN, ST_POST, ST_REL_RD, ST_REL_WR
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_ISSUE, PH_WAIT, PH_RESP
    } phase_e;
endpackage

// File: rtl/txeq_req_check.sv
// Request validator: checks the lane count against the supported set and the
// physical lane count, and checks the level sum of every active lane.
// Purely combinational; the levels of inactive lanes are not examined.
module txeq_req_check
    import txeq_pkg::*;
#(
    parameter int PHYS_LANES = 4
) (
    input  logic [CNT_W-1:0]            lanes,
    input  logic [PHYS_LANES*LVL_W-1:0] swing,
    input  logic [PHYS_LANES*LVL_W-1:0] pre,
    output logic                        ok
);
    logic             cnt_ok;
    logic             lvl_ok;
    logic [LVL_W:0]   sum;

    // Evaluate the lane-count rule and the per-lane level-sum rule.
    always_comb begin
        cnt_ok = (lanes == 3'd1) || (lanes == 3'd2) || (lanes == 3'd4);
        if (int'(lanes) > PHYS_LANES) cnt_ok = 1'b0;
        lvl_ok = 1'b1;
        sum    = '0;
        for (int i = 0; i < PHYS_LANES; i++) begin
            sum = {1'b0, swing[i*LVL_W +: LVL_W]} + {1'b0, pre[i*LVL_W +: LVL_W]};
            if ((i < int'(lanes)) && (sum > 3'd3)) lvl_ok = 1'b0;
        end
        ok = cnt_ok && lvl_ok;
    end
endmodule

// File: rtl/txeq_coef_lut.sv
// Coefficient table indexed by swing and pre-emphasis level. Combinations
// whose sum exceeds 3 return all ones; validation keeps them from being used.
module txeq_coef_lut
    import txeq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [LVL_W-1:0]  swing,
    input  logic [LVL_W-1:0]  pre,
    output logic [DATA_W-1:0] drv,
    output logic [DATA_W-1:0] main_m,
    output logic [DATA_W-1:0] post_m
);
    logic [15:0] m16;
    logic [15:0] p16;

    // Select main and post multipliers for the level pair.
    always_comb begin
        case ({swing, pre})
            4'b00_00: begin m16 = 16'h002A; p16 = 16'h0000; end
            4'b00_01: begin m16 = 16'h001F; p16 = 16'h0014; end
            4'b00_10: begin m16 = 16'h0012; p16 = 16'h0020; end
            4'b00_11: begin m16 = 16'h0000; p16 = 16'h002A; end
            4'b01_00: begin m16 = 16'h001F; p16 = 16'h0000; end
            4'b01_01: begin m16 = 16'h0013; p16 = 16'h0012; end
            4'b01_10: begin m16 = 16'h0000; p16 = 16'h001F; end
            4'b10_00: begin m16 = 16'h0013; p16 = 16'h0000; end
            4'b10_01: begin m16 = 16'h0000; p16 = 16'h0013; end
            4'b11_00: begin m16 = 16'h0000; p16 = 16'h0000; end
            default:  begin m16 = 16'hFFFF; p16 = 16'hFFFF; end
        endcase
    end

    assign drv    = DATA_W'(DRV_WORD);
    assign main_m = DATA_W'(m16);
    assign post_m = DATA_W'(p16);
endmodule

// File: rtl/txeq_lane_seq.sv
// Lane sequencer: captures an accepted request, walks lanes in ascending order
// through the eight-step freeze / program / release sequence, and holds the
// response until taken. Assumes at most one bus transaction in flight.
module txeq_lane_seq
    import txeq_pkg::*;
#(
    parameter int          PHYS_LANES = 4,
    parameter int          ADDR_W     = 20,
    parameter int          DATA_W     = 16,
    parameter int          LANE_SHIFT = 11,
    parameter logic [ADDR_W-1:0] OFS_HOLD = 20'h1079C,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 20'h10100,
    parameter logic [ADDR_W-1:0] OFS_DRV  = 20'h10318,
    parameter logic [ADDR_W-1:0] OFS_MAIN = 20'h10140,
    parameter logic [ADDR_W-1:0] OFS_POST = 20'h10130
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        start_ok,
    input  logic [CNT_W-1:0]            lanes,
    input  logic [PHYS_LANES*LVL_W-1:0] swing,
    input  logic [PHYS_LANES*LVL_W-1:0] pre,
    output logic                        idle,
    output logic [LVL_W-1:0]            cur_swing,
    output logic [LVL_W-1:0]            cur_pre,
    input  logic [DATA_W-1:0]           lut_drv,
    input  logic [DATA_W-1:0]           lut_main,
    input  logic [DATA_W-1:0]           lut_post,
    output logic                        rsp_valid,
    input  logic                        rsp_ready,
    output logic                        rsp_err,
    output logic                        m_req,
    output logic                        m_we,
    output logic [ADDR_W-1:0]           m_addr,
    output logic [DATA_W-1:0]           m_wdata,
    input  logic                        m_ready,
    input  logic [DATA_W-1:0]           m_rdata,
    input  logic                        m_rvalid
);
    localparam int LIDX_W = (PHYS_LANES > 1) ? $clog2(PHYS_LANES) : 1;

    phase_e                      phase_q;
    step_e                       step_q;
    logic [LIDX_W-1:0]           lane_q;
    logic [CNT_W-1:0]            lanes_q;
    logic [PHYS_LANES*LVL_W-1:0] swing_q;
    logic [PHYS_LANES*LVL_W-1:0] pre_q;
    logic [DATA_W-1:0]           hold_q;
    logic                        err_q;
    logic                        is_read;
    logic                        step_done;
    logic                        last_lane;
    logic [ADDR_W-1:0]           base;

    assign idle      = (phase_q == PH_IDLE);
    assign rsp_valid = (phase_q == PH_RESP);
    assign rsp_err   = err_q;
    assign m_req     = (phase_q == PH_ISSUE);
    assign is_read   = (step_q == ST_FRZ_RD) || (step_q == ST_REL_RD);
    assign m_we      = !is_read;
    assign cur_swing = swing_q[LVL_W*int'(lane_q) +: LVL_W];
    assign cur_pre   = pre_q[LVL_W*int'(lane_q) +: LVL_W];
    assign last_lane = ((CNT_W'(lane_q) + 3'd1) == lanes_q);
    assign step_done = ((phase_q == PH_ISSUE) && m_ready && !is_read) ||
                       ((phase_q == PH_WAIT) && m_rvalid);

    // Pick the register offset and write data for the current step.
    always_comb begin
        base    = OFS_HOLD;
        m_wdata = '0;
        case (step_q)
            ST_FRZ_WR: m_wdata = hold_q | DATA_W'(1);
            ST_CTRL:   begin base = OFS_CTRL; m_wdata = DATA_W'(CTRL_WORD); end
            ST_DRV:    begin base = OFS_DRV;  m_wdata = lut_drv;  end
            ST_MAIN:   begin base = OFS_MAIN; m_wdata = lut_main; end
            ST_POST:   begin base = OFS_POST; m_wdata = lut_post; end
            ST_REL_WR: m_wdata = hold_q & ~DATA_W'(1);
            default:   m_wdata = '0;
        endcase
    end

    assign m_addr = base | (ADDR_W'(lane_q) << LANE_SHIFT);

    // Phase, step and lane progression with request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= ST_FRZ_RD;
            lane_q  <= '0;
            lanes_q <= '0;
            swing_q <= '0;
            pre_q   <= '0;
            hold_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    lanes_q <= lanes;
                    swing_q <= swing;
                    pre_q   <= pre;
                    lane_q  <= '0;
                    step_q  <= ST_FRZ_RD;
                    err_q   <= !start_ok;
                    phase_q <= start_ok ? PH_ISSUE : PH_RESP;
                end
                PH_ISSUE: if (m_ready && is_read) phase_q <= PH_WAIT;
                PH_WAIT:  if (m_rvalid) hold_q <= m_rdata;
                PH_RESP:  if (rsp_ready) phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
            if (step_done) begin
                if (step_q == ST_REL_WR) begin
                    step_q <= ST_FRZ_RD;
                    if (last_lane) begin
                        phase_q <= PH_RESP;
                    end else begin
                        lane_q  <= lane_q + LIDX_W'(1);
                        phase_q <= PH_ISSUE;
                    end
                end else begin
                    step_q  <= step_e'(step_q + 3'd1);
                    phase_q <= PH_ISSUE;
                end
            end
        end
    end
endmodule

// File: rtl/txeq_prog.sv
// Top of the transmit equalization programmer: validates a request, then
// sequences per-lane register traffic on a single-outstanding master port.
// Assumes the responder returns read data with m_rvalid after acceptance.
module txeq_prog
    import txeq_pkg::*;
#(
    parameter int          PHYS_LANES = 4,
    parameter int          ADDR_W     = 20,
    parameter int          DATA_W     = 16,
    parameter int          LANE_SHIFT = 11,
    parameter logic [ADDR_W-1:0] OFS_HOLD = 20'h1079C,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 20'h10100,
    parameter logic [ADDR_W-1:0] OFS_DRV  = 20'h10318,
    parameter logic [ADDR_W-1:0] OFS_MAIN = 20'h10140,
    parameter logic [ADDR_W-1:0] OFS_POST = 20'h10130
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [2:0]                  req_lanes,
    input  logic [PHYS_LANES*2-1:0]     req_swing,
    input  logic [PHYS_LANES*2-1:0]     req_pre,
    output logic                        rsp_valid,
    input  logic                        rsp_ready,
    output logic                        rsp_err,
    output logic                        m_req,
    output logic                        m_we,
    output logic [ADDR_W-1:0]           m_addr,
    output logic [DATA_W-1:0]           m_wdata,
    input  logic                        m_ready,
    input  logic [DATA_W-1:0]           m_rdata,
    input  logic                        m_rvalid
);
    logic              req_ok;
    logic              idle;
    logic [LVL_W-1:0]  cur_swing;
    logic [LVL_W-1:0]  cur_pre;
    logic [DATA_W-1:0] lut_drv;
    logic [DATA_W-1:0] lut_main;
    logic [DATA_W-1:0] lut_post;

    assign req_ready = idle;

    txeq_req_check #(.PHYS_LANES(PHYS_LANES)) u_check (
        .lanes (req_lanes),
        .swing (req_swing),
        .pre   (req_pre),
        .ok    (req_ok)
    );

    txeq_coef_lut #(.DATA_W(DATA_W)) u_lut (
        .swing  (cur_swing),
        .pre    (cur_pre),
        .drv    (lut_drv),
        .main_m (lut_main),
        .post_m (lut_post)
    );

    txeq_lane_seq #(
        .PHYS_LANES (PHYS_LANES),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LANE_SHIFT (LANE_SHIFT),
        .OFS_HOLD   (OFS_HOLD),
        .OFS_CTRL   (OFS_CTRL),
        .OFS_DRV    (OFS_DRV),
        .OFS_MAIN   (OFS_MAIN),
        .OFS_POST   (OFS_POST)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid && idle),
        .start_ok  (req_ok),
        .lanes     (req_lanes),
        .swing     (req_swing),
        .pre       (req_pre),
        .idle      (idle),
        .cur_swing (cur_swing),
        .cur_pre   (cur_pre),
        .lut_drv   (lut_drv),
        .lut_main  (lut_main),
        .lut_post  (lut_post),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_err   (rsp_err),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_ready   (m_ready),
        .m_rdata   (m_rdata),
        .m_rvalid  (m_rvalid)
    );
endmodule

// File: rtl/txeq_prog_sva.sv
// Protocol and ordering checker for txeq_prog, attached by bind. Tracks the
// accepted lane count and the number of completed transactions per request.
module txeq_prog_sva #(
    parameter int          PHYS_LANES = 4,
    parameter int          ADDR_W     = 20,
    parameter int          DATA_W     = 16,
    parameter int          LANE_SHIFT = 11,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 20'h10100,
    parameter logic [ADDR_W-1:0] OFS_DRV  = 20'h10318
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_lanes,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_err,
    input logic              m_req,
    input logic              m_we,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_ready
);
    localparam int LIDX_W = (PHYS_LANES > 1) ? $clog2(PHYS_LANES) : 1;
    localparam logic [ADDR_W-1:0] LMASK = ADDR_W'((2 ** LIDX_W) - 1) << LANE_SHIFT;

    logic [2:0]  lanes_cap;
    logic [7:0]  acc_cnt;
    logic [ADDR_W-1:0] base;

    assign base = m_addr & ~LMASK;

    // Capture lane count and count completed transactions per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_cap <= '0;
            acc_cnt   <= '0;
        end else if (req_valid && req_ready) begin
            lanes_cap <= req_lanes;
            acc_cnt   <= '0;
        end else if (m_req && m_ready) begin
            acc_cnt <= acc_cnt + 8'd1;
        end
    end

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ready |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));

    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err));

    a_r10_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> !req_ready && !rsp_valid);

    a_r1_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> acc_cnt == 8'd0);

    a_r3_eight_per_lane: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_err |-> acc_cnt == {2'b0, lanes_cap, 3'b000});

    a_r6_ctrl_word: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && m_we && (base == OFS_CTRL) |-> m_wdata == DATA_W'(16'h08A4));

    a_r6_drv_word: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && m_we && (base == OFS_DRV) |-> m_wdata == DATA_W'(16'h0003));

    a_r8_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> 3'(m_addr[LANE_SHIFT +: LIDX_W]) < lanes_cap);
endmodule

bind txeq_prog txeq_prog_sva #(
    .PHYS_LANES (PHYS_LANES),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LANE_SHIFT (LANE_SHIFT),
    .OFS_CTRL   (OFS_CTRL),
    .OFS_DRV    (OFS_DRV)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_lanes (req_lanes),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .m_req     (m_req),
    .m_we      (m_we),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .m_ready   (m_ready)
);

// File: tb/txeq_prog_bench.sv
// Directed bench for txeq_prog: a register responder logs every accepted
// transaction; each scenario task compares the log and response to values
// derived from the requirements.
module txeq_prog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_lanes = '0;
    logic [7:0]  req_swing = '0;
    logic [7:0]  req_pre = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_err;
    logic        m_req;
    logic        m_we;
    logic [19:0] m_addr;
    logic [15:0] m_wdata;
    logic        m_ready = 1'b0;
    logic [15:0] m_rdata = '0;
    logic        m_rvalid = 1'b0;

    int vectors = 0;
    int errors  = 0;
    bit stall   = 1'b0;
    int cyc     = 0;
    int rd_cnt  = 0;
    bit rd_pend = 1'b0;
    int lg_n    = 0;
    logic        lg_we   [64];
    logic [19:0] lg_addr [64];
    logic [15:0] lg_wdata[64];

    always #(CLK_PERIOD/2) clk = ~clk;

    txeq_prog u_txeq_prog (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lanes(req_lanes),
        .req_swing(req_swing), .req_pre(req_pre),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata), .m_rvalid(m_rvalid)
    );

    function automatic logic [15:0] rd_val(input int idx);
        return 16'h9A00 | 16'(idx[7:0]);
    endfunction

    function automatic logic [15:0] exp_main(input int s, input int p);
        logic [15:0] v;
        v = 16'h0000;
        if (s == 0) v = (p == 0) ? 16'h2A : (p == 1) ? 16'h1F : (p == 2) ? 16'h12 : 16'h00;
        if (s == 1) v = (p == 0) ? 16'h1F : (p == 1) ? 16'h13 : 16'h00;
        if (s == 2) v = (p == 0) ? 16'h13 : 16'h00;
        return v;
    endfunction

    function automatic logic [15:0] exp_post(input int s, input int p);
        logic [15:0] v;
        v = 16'h0000;
        if (s == 0) v = (p == 1) ? 16'h14 : (p == 2) ? 16'h20 : (p == 3) ? 16'h2A : 16'h00;
        if (s == 1) v = (p == 1) ? 16'h12 : (p == 2) ? 16'h1F : 16'h00;
        if (s == 2) v = (p == 1) ? 16'h13 : 16'h00;
        return v;
    endfunction

    // Responder: decides m_ready, logs accepted transactions, returns read data.
    always @(negedge clk) begin
        cyc++;
        if (rd_pend) begin
            m_rvalid = 1'b1;
            m_rdata  = rd_val(rd_cnt);
            rd_cnt++;
            rd_pend  = 1'b0;
        end else begin
            m_rvalid = 1'b0;
        end
        m_ready = stall ? (cyc % 3 == 0) : 1'b1;
        if (rst_n && m_req && m_ready && !rd_pend) begin
            if (lg_n < 64) begin
                lg_we[lg_n]    = m_we;
                lg_addr[lg_n]  = m_addr;
                lg_wdata[lg_n] = m_wdata;
            end
            lg_n++;
            if (!m_we) rd_pend = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one request, optionally hold the response, then check log and response.
    task automatic run_req(input int n, input logic [7:0] sw, input logic [7:0] pr,
                           input bit exp_err, input int hold, input string req);
        int rd0;
        int w;
        logic [19:0] la;
        lg_n = 0;
        rd0  = rd_cnt;
        @(negedge clk);
        req_lanes = 3'(n);
        req_swing = sw;
        req_pre   = pr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!rsp_valid && w < 2000) begin
            @(negedge clk);
            w++;
        end
        chk(rsp_valid == 1'b1, req, "response present", 32'(rsp_valid), 32'd1);
        chk(rsp_err == exp_err, req, "rsp_err", 32'(rsp_err), 32'(exp_err));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b1 && rsp_err == exp_err, "R10", "response held",
                {30'd0, rsp_valid, rsp_err}, {30'd0, 1'b1, exp_err});
            chk(req_ready == 1'b0, "R10", "req_ready while responding", 32'(req_ready), 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready == 1'b1, "R10", "idle after response", 32'(req_ready), 32'd1);
        if (exp_err) begin
            chk(lg_n == 0, req, "no register access on reject", 32'(lg_n), 32'd0);
        end else begin
            chk(lg_n == 8 * n, "R3", "transaction count", 32'(lg_n), 32'(8 * n));
            for (int l = 0; l < n && lg_n == 8 * n; l++) begin
                int s = int'(sw[2*l +: 2]);
                int p = int'(pr[2*l +: 2]);
                int b = 8 * l;
                la = 20'(l) << 11;
                chk(lg_we[b] == 1'b0 && lg_addr[b] == (20'h1079C | la), "R8", "hold read address",
                    {11'd0, lg_we[b], lg_addr[b]}, {12'd0, 20'h1079C | la});
                chk(lg_we[b+1] && lg_addr[b+1] == (20'h1079C | la), "R4", "hold write address",
                    32'(lg_addr[b+1]), 32'(20'h1079C | la));
                chk(lg_wdata[b+1] == (rd_val(rd0 + 2*l) | 16'h1), "R5", "freeze data",
                    32'(lg_wdata[b+1]), 32'(rd_val(rd0 + 2*l) | 16'h1));
                chk(lg_we[b+2] && lg_addr[b+2] == (20'h10100 | la) && lg_wdata[b+2] == 16'h08A4,
                    "R6", "control write", {lg_addr[b+2], 12'd0} | 32'(lg_wdata[b+2]),
                    {20'h10100 | la, 12'd0} | 32'h08A4);
                chk(lg_we[b+3] && lg_addr[b+3] == (20'h10318 | la) && lg_wdata[b+3] == 16'h0003,
                    "R6", "drive write", {lg_addr[b+3], 12'd0} | 32'(lg_wdata[b+3]),
                    {20'h10318 | la, 12'd0} | 32'h0003);
                chk(lg_we[b+4] && lg_addr[b+4] == (20'h10140 | la) && lg_wdata[b+4] == exp_main(s, p),
                    "R7", "main multiplier", {lg_addr[b+4], 12'd0} | 32'(lg_wdata[b+4]),
                    {20'h10140 | la, 12'd0} | 32'(exp_main(s, p)));
                chk(lg_we[b+5] && lg_addr[b+5] == (20'h10130 | la) && lg_wdata[b+5] == exp_post(s, p),
                    "R7", "post multiplier", {lg_addr[b+5], 12'd0} | 32'(lg_wdata[b+5]),
                    {20'h10130 | la, 12'd0} | 32'(exp_post(s, p)));
                chk(!lg_we[b+6] && lg_addr[b+6] == (20'h1079C | la), "R3", "second hold read",
                    {11'd0, lg_we[b+6], lg_addr[b+6]}, {12'd0, 20'h1079C | la});
                chk(lg_we[b+7] && lg_addr[b+7] == (20'h1079C | la) &&
                    lg_wdata[b+7] == (rd_val(rd0 + 2*l + 1) & ~16'h1), "R5", "release data",
                    32'(lg_wdata[b+7]), 32'(rd_val(rd0 + 2*l + 1) & ~16'h1));
            end
        end
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10", "reset req_ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(m_req == 1'b0, "R9", "reset m_req", 32'(m_req), 32'd0);
    endtask

    task automatic t_single_lane();
        run_req(1, 8'h00, 8'h00, 1'b0, 0, "R3");
    endtask

    task automatic t_two_lanes_stall();
        stall = 1'b1;
        run_req(2, 8'b00_00_10_01, 8'b00_00_01_01, 1'b0, 0, "R9");
        stall = 1'b0;
    endtask

    task automatic t_four_lanes();
        run_req(4, 8'b00_01_11_00, 8'b01_10_00_11, 1'b0, 2, "R8");
    endtask

    task automatic t_bad_counts();
        run_req(3, 8'h00, 8'h00, 1'b1, 0, "R1");
        run_req(0, 8'h00, 8'h00, 1'b1, 0, "R1");
        run_req(5, 8'h00, 8'h00, 1'b1, 0, "R1");
    endtask

    task automatic t_level_sum();
        run_req(2, 8'b00_00_11_00, 8'b00_00_01_00, 1'b1, 0, "R2");
        run_req(4, 8'b10_00_00_00, 8'b10_00_00_00, 1'b1, 0, "R2");
        run_req(2, 8'b11_11_00_00, 8'b11_11_00_00, 1'b0, 0, "R2");
    endtask

    task automatic t_table_sweep();
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p + s < 4; p++) begin
                run_req(1, 8'(s), 8'(p), 1'b0, 0, "R7");
            end
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_lane();
        t_two_lanes_stall();
        t_four_lanes();
        t_bad_counts();
        t_level_sum();
        t_table_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule